// File: doc/BRIEF.md
# Fixed-Point Add Unit with Carry, Overflow and Condition Flags

This block is the add stage of a fixed-point execution pipeline. Each accepted operation takes two register operands, a 16-bit immediate, an operation code and the overflow-enable and record-enable bits. It produces the registered sum together with updated copies of the exception-flag word and the condition word. The flag word holds a sticky summary-overflow bit, an overflow bit and a carry bit in its three most significant positions. The condition word's top nibble is rewritten from the sum when recording is enabled.

Eight add flavours are supported: plain, carrying, carry-in extended, carry-in plus all-ones, carry-in plus zero, sign-extended immediate, upper-halfword immediate and carrying immediate. The carry-in forms take the current carry bit from the incoming flag word as a third addend. When overflow-enable and record-enable are both set, the overflow update is applied first, so the summary bit copied into the condition nibble is the freshly updated one. The unit's caller keeps the architectural flag and condition words and feeds them back on later operations.

Top module: `fxadd_flags_unit`

## Requirements
- R1: An operation presented with in_valid high at a rising edge shows out_valid high after that edge; with in_valid low at an edge, out_valid is low after it.
- R2: op_sel selects the addends: 0 a+b, 1 a+b (carrying), 2 a+b+CA, 3 a+CA+0xFFFFFFFF, 4 a+CA, 5 (0 if ra_zero else a)+sign-extended imm, 6 (0 if ra_zero else a)+(imm shifted into the upper 16 bits), 7 a+sign-extended imm. The sum is taken modulo 2^32.
- R3: Ops 1, 2, 3, 4 and 7 write flag bit 29 (CA) as 1 when the unsigned sum of the addends exceeds 0xFFFFFFFF, otherwise 0. Ops 0, 5 and 6 pass CA through from the flag input.
- R4: For ops 0 to 4 with oe_en high, flag bit 30 (OV) becomes 1 when the signed sum does not fit in 32 bits, and flag bit 31 (SO) is then set too. Without overflow OV is cleared and SO keeps its input value. Ops 5 to 7, or oe_en low, leave OV and SO unchanged.
- R5: For ops 0 to 4 and 7 with rc_en high, condition bit 31 (LT) is the sum's sign, bit 30 (GT) is set when the sign is clear and the sum is nonzero, and bit 29 (EQ) is set when the sum is zero. Ops 5 and 6 ignore rc_en and leave the condition word unchanged.
- R6: When the condition nibble is written, bit 28 copies the flag SO bit after the R4 update of the same operation.
- R7: Flag bits 28..0 and condition bits 27..0 always pass through from the inputs unchanged.
- R8: ra_zero only affects ops 5 and 6; all other ops always use operand a.
- R9: During reset out_valid is low and sum, flag and condition outputs are zero.
- R10: While in_valid is low the sum, flag and condition outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Add flavour, encoding per R2 |
| oe_en | input | 1 | Overflow update enable |
| rc_en | input | 1 | Condition nibble record enable |
| ra_zero | input | 1 | Register field is zero; selects literal zero for ops 5 and 6 |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate field |
| xer_in | input | 32 | Current flag word |
| cr_in | input | 32 | Current condition word |
| out_valid | output | 1 | Registered result valid |
| sum_out | output | 32 | Registered sum |
| xer_out | output | 32 | Updated flag word |
| cr_out | output | 32 | Updated condition word |

## Verification
Every result, the sum and both flag words alike, is due exactly one rising edge after the operation is sampled, because a single register stage holds all of them. The bench drives inputs on the falling edge, lets the next rising edge capture them, and compares all three outputs on the following falling edge against a 64-bit reference computed in the bench. Idle cycles are inserted between some operations and the outputs are compared again to confirm they hold.

// File: rtl/fxadd_pkg.sv
package fxadd_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_ADDC  = 3'd1,
        OP_ADDE  = 3'd2,
        OP_ADDM1 = 3'd3,
        OP_ADDZ  = 3'd4,
        OP_ADDI  = 3'd5,
        OP_ADDIH = 3'd6,
        OP_ADDIC = 3'd7
    } add_op_e;

    function automatic logic op_writes_ca(add_op_e op);
        return (op == OP_ADDC) || (op == OP_ADDE) || (op == OP_ADDM1) ||
               (op == OP_ADDZ) || (op == OP_ADDIC);
    endfunction

    function automatic logic op_takes_oe(add_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_ADDE) ||
               (op == OP_ADDM1) || (op == OP_ADDZ);
    endfunction

    function automatic logic op_takes_rc(add_op_e op);
        return (op != OP_ADDI) && (op != OP_ADDIH);
    endfunction

endpackage

// File: rtl/fxadd_opsel.sv
module fxadd_opsel
    import fxadd_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  add_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [IW-1:0]  imm,
    input  logic           ra_zero,
    input  logic           ca_in,
    output logic [W-1:0]   x,
    output logic [W-1:0]   y,
    output logic           cin
);
    localparam int EXT = W - IW;

    logic [W-1:0] imm_sext;
    logic [W-1:0] imm_high;
    logic [W-1:0] a_or_zero;

    assign imm_sext  = {{EXT{imm[IW-1]}}, imm};
    assign imm_high  = {imm, {EXT{1'b0}}};
    assign a_or_zero = ra_zero ? '0 : a;

    always_comb begin
        x   = a;
        y   = b;
        cin = 1'b0;
        unique case (op)
            OP_ADD, OP_ADDC: begin
                y = b;
            end
            OP_ADDE: begin
                cin = ca_in;
            end
            OP_ADDM1: begin
                y   = '1;
                cin = ca_in;
            end
            OP_ADDZ: begin
                y   = '0;
                cin = ca_in;
            end
            OP_ADDI: begin
                x = a_or_zero;
                y = imm_sext;
            end
            OP_ADDIH: begin
                x = a_or_zero;
                y = imm_high;
            end
            OP_ADDIC: begin
                y = imm_sext;
            end
            default: begin
                y = b;
            end
        endcase
    end
endmodule

// File: rtl/fxadd_core.sv
module fxadd_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         ovf
);
    logic [W:0] usum;
    logic [W:0] ssum;

    always_comb begin
        usum  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        ssum  = {x[W-1], x} + {y[W-1], y} + {{W{1'b0}}, cin};
        res   = usum[W-1:0];
        carry = usum[W];
        ovf   = ssum[W] ^ ssum[W-1];
    end
endmodule

// File: rtl/fxadd_flags.sv
module fxadd_flags
    import fxadd_pkg::*;
#(
    parameter int W = 32
) (
    input  add_op_e       op,
    input  logic          oe_en,
    input  logic          rc_en,
    input  logic [W-1:0]  res,
    input  logic          carry,
    input  logic          ovf,
    input  logic [W-1:0]  xer_in,
    input  logic [W-1:0]  cr_in,
    output logic [W-1:0]  xer_nx,
    output logic [W-1:0]  cr_nx
);
    localparam int SO_B = W - 1;
    localparam int OV_B = W - 2;
    localparam int CA_B = W - 3;
    localparam int LT_B = W - 1;
    localparam int GT_B = W - 2;
    localparam int EQ_B = W - 3;
    localparam int CS_B = W - 4;

    logic res_zero;
    assign res_zero = (res == '0);

    always_comb begin
        xer_nx = xer_in;
        if (op_writes_ca(op)) begin
            xer_nx[CA_B] = carry;
        end
        if (oe_en && op_takes_oe(op)) begin
            xer_nx[OV_B] = ovf;
            if (ovf) begin
                xer_nx[SO_B] = 1'b1;
            end
        end

        cr_nx = cr_in;
        if (rc_en && op_takes_rc(op)) begin
            cr_nx[LT_B] = res[W-1];
            cr_nx[GT_B] = !res[W-1] && !res_zero;
            cr_nx[EQ_B] = res_zero;
            cr_nx[CS_B] = xer_nx[SO_B];
        end
    end
endmodule

// File: rtl/fxadd_flags_unit.sv
module fxadd_flags_unit
    import fxadd_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    op_sel,
    input  logic          oe_en,
    input  logic          rc_en,
    input  logic          ra_zero,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [IW-1:0] imm16,
    input  logic [W-1:0]  xer_in,
    input  logic [W-1:0]  cr_in,
    output logic          out_valid,
    output logic [W-1:0]  sum_out,
    output logic [W-1:0]  xer_out,
    output logic [W-1:0]  cr_out
);
    localparam int SO_B = W - 1;
    localparam int OV_B = W - 2;
    localparam int LT_B = W - 1;
    localparam int EQ_B = W - 3;
    localparam int CS_B = W - 4;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] sum;
        logic [W-1:0] xer;
        logic [W-1:0] cr;
    } unit_state_t;

    add_op_e      op;
    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic         add_cin;
    logic [W-1:0] add_res;
    logic         add_carry;
    logic         add_ovf;
    logic [W-1:0] xer_nx;
    logic [W-1:0] cr_nx;
    unit_state_t  st_d;
    unit_state_t  st_q;

    assign op = add_op_e'(op_sel);

    fxadd_opsel #(.W(W), .IW(IW)) i_opsel (
        .op      (op),
        .a       (opnd_a),
        .b       (opnd_b),
        .imm     (imm16),
        .ra_zero (ra_zero),
        .ca_in   (xer_in[W-3]),
        .x       (add_x),
        .y       (add_y),
        .cin     (add_cin)
    );

    fxadd_core #(.W(W)) i_core (
        .x     (add_x),
        .y     (add_y),
        .cin   (add_cin),
        .res   (add_res),
        .carry (add_carry),
        .ovf   (add_ovf)
    );

    fxadd_flags #(.W(W)) i_flags (
        .op     (op),
        .oe_en  (oe_en),
        .rc_en  (rc_en),
        .res    (add_res),
        .carry  (add_carry),
        .ovf    (add_ovf),
        .xer_in (xer_in),
        .cr_in  (cr_in),
        .xer_nx (xer_nx),
        .cr_nx  (cr_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.sum = add_res;
            st_d.xer = xer_nx;
            st_d.cr  = cr_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign sum_out   = st_q.sum;
    assign xer_out   = st_q.xer;
    assign cr_out    = st_q.cr;

    logic oe_applies;
    logic rc_applies;
    assign oe_applies = in_valid && oe_en && op_takes_oe(op);
    assign rc_applies = in_valid && rc_en && op_takes_rc(op);

    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_so_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xer_in[SO_B]) |=> xer_out[SO_B]);
    assert_no_ov_without_so_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_applies |=> (!xer_out[OV_B] || xer_out[SO_B]));
    assert_cr_so_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rc_applies |=> (cr_out[CS_B] == xer_out[SO_B]));
    assert_cr_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rc_applies |=> ($countones(cr_out[LT_B:EQ_B]) == 1));
    assert_cr_low_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (cr_out[CS_B-1:0] == $past(cr_in[CS_B-1:0])));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_out) && $stable(xer_out) && $stable(cr_out)));
endmodule

// File: tb/test_fxadd_flags_unit.sv
module test_fxadd_flags_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        oe_en = 1'b0;
    logic        rc_en = 1'b0;
    logic        ra_zero = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] imm16 = '0;
    logic [31:0] xer_in = '0;
    logic [31:0] cr_in = '0;
    logic        out_valid;
    logic [31:0] sum_out;
    logic [31:0] xer_out;
    logic [31:0] cr_out;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxadd_flags_unit i_fxadd_flags_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .oe_en(oe_en), .rc_en(rc_en), .ra_zero(ra_zero), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .imm16(imm16), .xer_in(xer_in), .cr_in(cr_in),
        .out_valid(out_valid), .sum_out(sum_out), .xer_out(xer_out), .cr_out(cr_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void ref_model(
        input  logic [2:0] op, input logic oe, input logic rc, input logic raz,
        input  logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
        input  logic [31:0] xi, input logic [31:0] ci,
        output logic [31:0] s, output logic [31:0] xo, output logic [31:0] co);
        logic [31:0] x, y, se;
        logic        cin;
        logic [63:0] us;
        longint      ss;
        logic        ovf;
        se  = {{16{imm[15]}}, imm};
        cin = 1'b0;
        x   = a;
        y   = b;
        case (op)
            3'd2: cin = xi[29];
            3'd3: begin y = 32'hFFFF_FFFF; cin = xi[29]; end
            3'd4: begin y = 32'h0; cin = xi[29]; end
            3'd5: begin x = raz ? 32'h0 : a; y = se; end
            3'd6: begin x = raz ? 32'h0 : a; y = {imm, 16'h0}; end
            3'd7: y = se;
            default: ;
        endcase
        us  = {32'h0, x} + {32'h0, y} + {63'h0, cin};
        s   = us[31:0];
        ss  = longint'($signed(x)) + longint'($signed(y)) + longint'(cin);
        ovf = (ss != longint'($signed(s)));
        xo  = xi;
        if (op inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd7}) xo[29] = us[32];
        if (oe && op <= 3'd4) begin
            xo[30] = ovf;
            if (ovf) xo[31] = 1'b1;
        end
        co = ci;
        if (rc && !(op inside {3'd5, 3'd6})) begin
            co[31] = s[31];
            co[30] = !s[31] && (s != 0);
            co[29] = (s == 0);
            co[28] = xo[31];
        end
    endfunction

    task automatic run_op(input string tag, input logic [2:0] op, input logic oe,
                          input logic rc, input logic raz, input logic [31:0] a,
                          input logic [31:0] b, input logic [15:0] imm,
                          input logic [31:0] xi, input logic [31:0] ci);
        logic [31:0] es, ex, ec;
        ref_model(op, oe, rc, raz, a, b, imm, xi, ci, es, ex, ec);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; oe_en = oe; rc_en = rc; ra_zero = raz;
        opnd_a = a; opnd_b = b; imm16 = imm; xer_in = xi; cr_in = ci;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R1 valid"}, {31'h0, out_valid}, 32'h1);
        chk({tag, " sum"}, sum_out, es);
        chk({tag, " xer"}, xer_out, ex);
        chk({tag, " cr"}, cr_out, ec);
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 7))
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] hs, hx, hc;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 out_valid", {31'h0, out_valid}, 32'h0);
        chk("R9 sum", sum_out, 32'h0);
        chk("R9 xer", xer_out, 32'h0);
        chk("R9 cr", cr_out, 32'h0);
        rst_n = 1'b1;

        // R4 R6: signed overflow with both enables, sticky bit reaches condition nibble
        run_op("R4 R6 max+1", 3'd0, 1'b1, 1'b1, 1'b0, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h0, 32'h0);
        chk("R4 literal sum", sum_out, 32'h8000_0000);
        chk("R6 literal cr", cr_out, 32'h9000_0000);
        chk("R4 literal xer", xer_out, 32'hC000_0000);
        // R4: no overflow clears OV, keeps SO
        run_op("R4 sticky", 3'd0, 1'b1, 1'b0, 1'b0, 32'h5, 32'h6, 16'h0, 32'hC000_0000, 32'h0);
        chk("R4 literal keep SO", xer_out, 32'h8000_0000);
        // R3: carry out of all-ones plus one, EQ set
        run_op("R3 R5 wrap", 3'd1, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h1, 16'h0, 32'h0, 32'h0);
        chk("R3 literal CA", xer_out, 32'h2000_0000);
        chk("R5 literal EQ", cr_out, 32'h2000_0000);
        // R3: plain add leaves CA unchanged
        run_op("R3 plain keeps CA", 3'd0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h1, 16'h0, 32'h2000_0000, 32'h0);
        chk("R3 literal plain", xer_out, 32'h2000_0000);
        // R2: carry-in forms
        run_op("R2 ext ca", 3'd2, 1'b1, 1'b1, 1'b0, 32'h7FFF_FFFF, 32'h0, 16'h0, 32'h2000_0000, 32'h0);
        run_op("R2 m1 ca0", 3'd3, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 16'h0, 32'h0, 32'h0);
        chk("R2 literal m1", sum_out, 32'hFFFF_FFFF);
        run_op("R2 m1 ca1", 3'd3, 1'b1, 1'b1, 1'b0, 32'h8000_0000, 32'h0, 16'h0, 32'h2000_0000, 32'h0);
        run_op("R2 ze ca1", 3'd4, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0, 16'h0, 32'h2000_0000, 32'h0);
        // R8: ra_zero on immediates and ignored elsewhere
        run_op("R8 addi raz", 3'd5, 1'b1, 1'b1, 1'b1, 32'h1234_5678, 32'h0, 16'hFFFE, 32'h0, 32'h0);
        chk("R8 literal addi", sum_out, 32'hFFFF_FFFE);
        run_op("R8 addih", 3'd6, 1'b0, 1'b0, 1'b0, 32'h0000_0010, 32'h0, 16'h8001, 32'h0, 32'h0);
        chk("R8 literal addih", sum_out, 32'h8001_0010);
        run_op("R8 add raz ignored", 3'd0, 1'b0, 1'b0, 1'b1, 32'h10, 32'h20, 16'h0, 32'h0, 32'h0);
        chk("R8 literal add", sum_out, 32'h30);
        // R5 R3: recording carrying immediate
        run_op("R5 addic", 3'd7, 1'b1, 1'b1, 1'b0, 32'h1, 16'hFFFF, 16'hFFFF, 32'h0, 32'h0);
        chk("R5 literal addic cr", cr_out, 32'h2000_0000);
        chk("R3 literal addic ca", xer_out, 32'h2000_0000);
        // R7: pass-through of low bits
        run_op("R7 pass", 3'd2, 1'b1, 1'b1, 1'b0, 32'h3, 32'h4, 16'h0, 32'h2ABC_DEF1, 32'h0765_4321);

        // R10: outputs hold while idle
        hs = sum_out; hx = xer_out; hc = cr_out;
        opnd_a = 32'hDEAD_BEEF; opnd_b = 32'h1111_1111; cr_in = 32'hFFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        chk("R10 sum hold", sum_out, hs);
        chk("R10 xer hold", xer_out, hx);
        chk("R10 cr hold", cr_out, hc);
        chk("R1 idle valid", {31'h0, out_valid}, 32'h0);

        // Random mix covering R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 400; i++) begin
            run_op("R2 rnd", 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), pick_val(), pick_val(),
                   16'($urandom()), $urandom(), $urandom());
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule